// File: doc/BRIEF.md
# Parallel multi-symbol variable-length decoder

This block decodes a prefix-free variable-length code several codewords at a time. Each accepted input is a 32-bit window of the coded stream, left-aligned, so that window bit 0 is the most significant bit of `in_window`. A codeword detector sits at every bit offset of the window, and all of them evaluate together. A serial chain then starts at offset 0. At each step it takes the length found at the current offset, uses it to jump to the next start, and stops when the next codeword does not fit, when an invalid pattern appears, or when the symbol slots are full.

The block reports the decoded symbols, how many are valid and how many window bits they used. An external barrel shifter advances the stream by that bit count and presents the next window. The code table is fixed and built into the detectors.

Top module: `vld_multi_decode`

## Requirements
- R1: Codewords are decoded back to back from window bit 0 (the MSB of `in_window`). A codeword is k leading ones (k = 0..7), then a zero, then p(k) payload bits, MSB first, with p = 0,1,2,3,3,2,1,0 for k = 0..7. Its length is k+1+p(k), and its symbol value is 16*k + payload.
- R2: Decoding stops before a codeword whose last bit would fall beyond window bit 31. That codeword is left for the next window.
- R3: At most 8 codewords are decoded per window. Decoding stops after the eighth even when more complete codewords are present.
- R4: Decoded symbols are placed in decode order, with slot s in bits [8s+7:8s] of `out_symbols`. Slots at or above the count read zero.
- R5: `out_count` equals the number of codewords decoded from the window (0 to 8).
- R6: `out_shift` equals the sum of the lengths of the decoded codewords (0 to 32).
- R7: Eight consecutive ones lying wholly inside the window at the point where the next codeword would start form an invalid pattern. Decoding stops there and `out_error` is set. When the invalid pattern is at bit 0, the result is zero symbols, shift 0 and `out_error` set. A run of ones cut off by the window end is not an error.
- R8: A window accepted at a clock edge (`in_valid` and `in_ready` both high) produces `out_valid` high with its results after that same edge. `out_valid` is low after any edge with no accepted window.
- R9: While `rst_n` is low, all outputs are cleared and `in_ready` is low. `in_ready` is high from the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window present |
| in_ready | output | 1 | Block accepts a window |
| in_window | input | 32 | Coded window, bit 0 of the stream at the MSB |
| out_valid | output | 1 | Result registers hold a new result |
| out_symbols | output | 64 | Eight 8-bit symbol slots, slot 0 lowest |
| out_count | output | 4 | Number of valid symbols |
| out_shift | output | 6 | Bits consumed from the window |
| out_error | output | 1 | Decoding stopped on an invalid pattern |

## Verification
Every result is due in the output registers one edge after its window is accepted. The bench drives a window at a falling edge and compares all result fields at the following falling edge, while the next window goes in at that same moment, so back-to-back acceptance is covered. Expected values come from a one-codeword-at-a-time decoder in the bench. That decoder runs over a random bit stream that the bench realigns by the expected shift. Directed windows cover the slot limit, a codeword that crosses the window end, a run of ones cut off at the tail, and invalid patterns at bit 0 and mid-window.

// File: rtl/vld_pkg.sv
package vld_pkg;
    localparam int CW_MAX = 8;
    localparam int SYM_W  = 8;
    localparam int LEN_W  = $clog2(CW_MAX + 1);

    function automatic logic [1:0] payload_width(input logic [2:0] k);
        case (k)
            3'd0: payload_width = 2'd0;
            3'd1: payload_width = 2'd1;
            3'd2: payload_width = 2'd2;
            3'd3: payload_width = 2'd3;
            3'd4: payload_width = 2'd3;
            3'd5: payload_width = 2'd2;
            3'd6: payload_width = 2'd1;
            default: payload_width = 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/vld_cw_detect.sv
module vld_cw_detect
    import vld_pkg::*;
(
    input  logic [CW_MAX-1:0] peek,
    output logic [LEN_W-1:0]  cw_len,
    output logic [SYM_W-1:0]  cw_sym,
    output logic              cw_inv
);
    logic [3:0]        ones_d;
    logic              run_d;
    logic [1:0]        pw_d;
    logic [CW_MAX-1:0] after_d;
    logic [2:0]        pay_d;

    always_comb begin
        ones_d = 4'd0;
        run_d  = 1'b1;
        for (int i = 0; i < CW_MAX; i++) begin
            if (run_d && peek[CW_MAX-1-i]) ones_d = ones_d + 4'd1;
            else                           run_d  = 1'b0;
        end
        cw_inv  = (ones_d == 4'(CW_MAX));
        pw_d    = payload_width(ones_d[2:0]);
        after_d = peek << (ones_d + 4'd1);
        pay_d   = after_d[CW_MAX-1 -: 3] >> (3'd3 - {1'b0, pw_d});
        if (cw_inv) begin
            cw_len = '0;
            cw_sym = '0;
        end else begin
            cw_len = LEN_W'(ones_d) + LEN_W'(1) + LEN_W'(pw_d);
            cw_sym = {1'b0, ones_d[2:0], 1'b0, pay_d};
        end
    end
endmodule

// File: rtl/vld_len_chain.sv
module vld_len_chain
    import vld_pkg::*;
#(
    parameter int WIN_W   = 32,
    parameter int MAX_SYM = 8,
    localparam int IDX_W  = $clog2(WIN_W),
    localparam int OFF_W  = $clog2(WIN_W + 1),
    localparam int CNT_W  = $clog2(MAX_SYM + 1)
) (
    input  logic [WIN_W-1:0][LEN_W-1:0]   det_len,
    input  logic [WIN_W-1:0][SYM_W-1:0]   det_sym,
    input  logic [WIN_W-1:0]              det_inv,
    output logic [MAX_SYM-1:0][SYM_W-1:0] chain_sym,
    output logic [CNT_W-1:0]              chain_cnt,
    output logic [OFF_W-1:0]              chain_shift,
    output logic                          chain_err
);
    logic [OFF_W-1:0] off_d;
    logic [IDX_W-1:0] idx_d;
    logic             live_d;

    always_comb begin
        off_d     = '0;
        idx_d     = '0;
        live_d    = 1'b1;
        chain_cnt = '0;
        chain_err = 1'b0;
        chain_sym = '0;
        for (int s = 0; s < MAX_SYM; s++) begin
            if (live_d) begin
                idx_d = off_d[IDX_W-1:0];
                if (int'(off_d) >= WIN_W) begin
                    live_d = 1'b0;
                end else if (det_inv[idx_d]) begin
                    live_d = 1'b0;
                    if (int'(off_d) + CW_MAX <= WIN_W) chain_err = 1'b1;
                end else if (int'(off_d) + int'(det_len[idx_d]) <= WIN_W) begin
                    chain_sym[s] = det_sym[idx_d];
                    off_d        = off_d + OFF_W'(det_len[idx_d]);
                    chain_cnt    = chain_cnt + CNT_W'(1);
                end else begin
                    live_d = 1'b0;
                end
            end
        end
        chain_shift = off_d;
    end
endmodule

// File: rtl/vld_multi_decode.sv
module vld_multi_decode
    import vld_pkg::*;
#(
    parameter int WIN_W   = 32,
    parameter int MAX_SYM = 8,
    localparam int OFF_W  = $clog2(WIN_W + 1),
    localparam int CNT_W  = $clog2(MAX_SYM + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [WIN_W-1:0]           in_window,
    output logic                       out_valid,
    output logic [MAX_SYM*SYM_W-1:0]   out_symbols,
    output logic [CNT_W-1:0]           out_count,
    output logic [OFF_W-1:0]           out_shift,
    output logic                       out_error
);
    typedef struct packed {
        logic                          rdy;
        logic                          vld;
        logic [MAX_SYM-1:0][SYM_W-1:0] sym;
        logic [CNT_W-1:0]              cnt;
        logic [OFF_W-1:0]              sh;
        logic                          err;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic [WIN_W+CW_MAX-1:0]       ext_win;
    logic [WIN_W-1:0][LEN_W-1:0]   det_len;
    logic [WIN_W-1:0][SYM_W-1:0]   det_sym;
    logic [WIN_W-1:0]              det_inv;
    logic [MAX_SYM-1:0][SYM_W-1:0] ch_sym;
    logic [CNT_W-1:0]              ch_cnt;
    logic [OFF_W-1:0]              ch_shift;
    logic                          ch_err;

    assign ext_win = {in_window, {CW_MAX{1'b1}}};

    for (genvar o = 0; o < WIN_W; o++) begin : g_det
        vld_cw_detect u_det (
            .peek   (ext_win[WIN_W+CW_MAX-1-o -: CW_MAX]),
            .cw_len (det_len[o]),
            .cw_sym (det_sym[o]),
            .cw_inv (det_inv[o])
        );
    end

    vld_len_chain #(.WIN_W(WIN_W), .MAX_SYM(MAX_SYM)) u_chain (
        .det_len     (det_len),
        .det_sym     (det_sym),
        .det_inv     (det_inv),
        .chain_sym   (ch_sym),
        .chain_cnt   (ch_cnt),
        .chain_shift (ch_shift),
        .chain_err   (ch_err)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
        st_d.vld = 1'b0;
        if (in_valid && st_q.rdy) begin
            st_d.vld = 1'b1;
            st_d.sym = ch_sym;
            st_d.cnt = ch_cnt;
            st_d.sh  = ch_shift;
            st_d.err = ch_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready    = st_q.rdy;
    assign out_valid   = st_q.vld;
    assign out_symbols = st_q.sym;
    assign out_count   = st_q.cnt;
    assign out_shift   = st_q.sh;
    assign out_error   = st_q.err;

    assert_ready_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);
    assert_result_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);
    assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_count) <= MAX_SYM));
    assert_shift_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_shift) >= int'(out_count)
                    && int'(out_shift) <= CW_MAX * int'(out_count)
                    && int'(out_shift) <= WIN_W));
    assert_empty_means_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_count == '0) |-> (out_error && out_shift == '0));
endmodule

// File: tb/vld_multi_decode_tb.sv
`timescale 1ns/1ps
module vld_multi_decode_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_window = '0;
    logic        out_valid;
    logic [63:0] out_symbols;
    logic [3:0]  out_count;
    logic [5:0]  out_shift;
    logic        out_error;

    int checks = 0;
    int fails  = 0;
    bit sq[$];

    always #2.5 clk = ~clk;

    vld_multi_decode u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_window(in_window), .out_valid(out_valid), .out_symbols(out_symbols),
        .out_count(out_count), .out_shift(out_shift), .out_error(out_error)
    );

    function automatic int pw(input int k);
        int t[8] = '{0, 1, 2, 3, 3, 2, 1, 0};
        return t[k];
    endfunction

    function automatic bit bit_at(input logic [31:0] w, input int i);
        return (i < 32) ? w[31-i] : 1'b1;
    endfunction

    // Serial reference: one codeword per step
    task automatic ref_decode(input logic [31:0] w, output logic [63:0] syms,
                              output int cnt, output int sh, output bit er);
        int  off = 0;
        bit  go  = 1;
        syms = '0; cnt = 0; sh = 0; er = 0;
        while (go && cnt < 8 && off < 32) begin
            int k = 0;
            while (k < 8 && bit_at(w, off + k)) k++;
            if (k == 8) begin
                if (off + 8 <= 32) er = 1;
                go = 0;
            end else begin
                int len = k + 1 + pw(k);
                if (off + len > 32) go = 0;
                else begin
                    int pay = 0;
                    for (int j = 0; j < pw(k); j++) pay = pay * 2 + int'(bit_at(w, off + k + 1 + j));
                    syms[cnt*8 +: 8] = 8'(k * 16 + pay);
                    cnt++;
                    off += len;
                end
            end
        end
        sh = off;
    endtask

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge
    task automatic send(input logic [31:0] w, input string tag);
        logic [63:0] es;
        int ec, esh;
        bit ee;
        ref_decode(w, es, ec, esh, ee);
        in_valid  = 1'b1;
        in_window = w;
        @(negedge clk);
        check({tag, " R8 out_valid"}, 64'(out_valid), 64'd1);
        check({tag, " R1/R4 symbols"}, out_symbols, es);
        check({tag, " R5 count"}, 64'(out_count), 64'(ec));
        check({tag, " R6 shift"}, 64'(out_shift), 64'(esh));
        check({tag, " R7 error"}, 64'(out_error), 64'(ee));
    endtask

    task automatic push_code();
        int k, p;
        if ($urandom_range(0, 15) == 0) begin
            for (int j = 0; j < 8; j++) sq.push_back(1'b1);
            return;
        end
        k = $urandom_range(0, 7);
        p = pw(k);
        for (int j = 0; j < k; j++) sq.push_back(1'b1);
        sq.push_back(1'b0);
        for (int j = 0; j < p; j++) sq.push_back(1'($urandom_range(0, 1)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] es;
        int ec, esh;
        bit ee;
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        in_window = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R9 reset out_valid", 64'(out_valid), 64'd0);
        check("R9 reset count", 64'(out_count), 64'd0);
        check("R9 reset shift", 64'(out_shift), 64'd0);
        check("R9 reset error", 64'(out_error), 64'd0);
        check("R9 reset symbols", out_symbols, 64'd0);
        check("R9 reset in_ready", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 in_ready after reset", 64'(in_ready), 64'd1);
        check("R8 idle out_valid", 64'(out_valid), 64'd0);

        send(32'h0000_0000, "R3 eight one-bit codes");
        send(32'hE1C3_870E, "R2 tail codeword crosses end");
        send(32'hE1C3_870F, "R7 truncated ones tail");
        send(32'hFF00_0000, "R7 invalid at bit 0");
        send(32'h7F80_0000, "R7 invalid mid-window");
        send(32'hFEFE_FEFE, "R1 four 8-bit codes");
        send(32'hA5C3_9E10, "R1 mixed lengths");

        for (int v = 0; v < 3000; v++) begin
            logic [31:0] w;
            while (sq.size() < 40) push_code();
            for (int j = 0; j < 32; j++) w[31-j] = sq[j];
            ref_decode(w, es, ec, esh, ee);
            send(w, "R2/R3 random stream");
            if (ec == 0) for (int j = 0; j < 8; j++) void'(sq.pop_front());
            else for (int j = 0; j < esh; j++) void'(sq.pop_front());
        end

        in_valid = 1'b0;
        @(negedge clk);
        check("R8 out_valid drops", 64'(out_valid), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule